// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block decides which exception a processor core should take next. It watches 32 external interrupt lines and two fixed system exceptions: a non-maskable request and a fault request. It keeps a record of the handlers that are currently active. When a pending request is strictly more urgent than the code now running, it raises a take request together with the exception number and its rank. It then waits for the core to report entry.

Each interrupt line has an enable bit and a two-bit priority, both written through a small register port. A line becomes pending on a rising edge while it is enabled. The pending bit clears when the core enters that exception. Active ranks are kept on a stack, so handlers nest and unwind in order.

On an exception return the controller can hand the core the next pending request at once, flagged as a chained take. While an entry is still outstanding, the offered exception is replaced whenever a more urgent request appears.

Top module: `irq_nest_ctrl`

## Requirements
- R1: A rising edge on `irq_in[n]` sets the pending state of line n only while enable bit n is 1. An edge seen while the line is disabled is lost, and enabling the line afterwards does not produce a take.
- R2: Writing address 0 loads the enable word, with bit n enabling line n. Writing address 1+n/8 loads the priority of line n from `cfg_wdata` bits [2*(n%8)+1 : 2*(n%8)]. After reset all enables are 0 and all priorities are 0.
- R3: Exception numbers are 2 for the non-maskable request, 3 for the fault request and 16+n for line n. Rank codes are 1 (non-maskable), 2 (fault), 3+p (line with priority p) and 7 (thread, no active handler). Code 0 is reserved for reset.
- R4: Among pending requests the lowest rank code wins. Non-maskable beats fault, and fault beats any line. Between lines of equal priority, the lower line number wins.
- R5: A pending request causes a take only when its rank code is strictly lower than `exec_rank`. An equal rank never preempts.
- R6: `take_req` rises two clock edges after the input edge and stays high until `entered` is sampled. At that edge the taken request's pending state clears and `exec_rank` becomes its rank.
- R7: While `take_req` is high and `entered` is low, a newly pending request with a lower rank code replaces `take_num`/`take_rank` one edge after it becomes pending. The replaced request stays pending.
- R8: `returned` pops the active stack. If the best pending request outranks the rank below the popped entry, a take with `take_chain`=1 starts at that same edge. Otherwise `exec_rank` falls back to that rank and the controller re-evaluates from there. Takes that do not follow a return have `take_chain`=0.
- R9: The active stack holds one entry per distinct rank (six by default) and never overflows. Each pushed rank is strictly lower than the rank it covers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 32 | External interrupt lines |
| nmi_in | input | 1 | Non-maskable request line (edge-detected) |
| fault_in | input | 1 | Fault request line (edge-detected) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| entered | input | 1 | Core has entered the offered exception |
| returned | input | 1 | Core has returned from the current handler |
| take_req | output | 1 | Request to take an exception |
| take_num | output | 6 | Exception number offered |
| take_rank | output | 3 | Rank code of the offered exception |
| take_chain | output | 1 | Offer follows a return directly (tail chain) |
| exec_rank | output | 3 | Current execution rank (7 = thread) |

## Verification
The assertions assume the core behaves as a core should. It pulses `entered` only while `take_req` is high. It never signals `returned` during an outstanding entry or with no handler active. The stimulus keeps to this by driving `entered` and `returned` as single-cycle pulses, only in the states where the sequence calls for them. Every raised line is dropped before it is raised again, so each test sees exactly the edges it intends.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
    localparam int N_IRQ         = 32;
    localparam int PRIO_W        = 2;
    localparam int N_LVL         = 1 << PRIO_W;
    localparam int RANK_W        = 3;
    localparam int NUM_W         = 6;
    localparam int CFG_AW        = 3;
    localparam int IRQ_PER_WORD  = 8;
    localparam int N_PRIO_WORDS  = N_IRQ / IRQ_PER_WORD;
    localparam int IRQ_BASE      = 16;
    localparam int NUM_NMI       = 2;
    localparam int NUM_FAULT     = 3;
    localparam int RANK_NMI      = 1;
    localparam int RANK_FAULT    = 2;
    localparam int RANK_LVL0     = 3;
    localparam int RANK_THREAD   = RANK_LVL0 + N_LVL;
    localparam int STACK_DEPTH   = N_LVL + 2;

    typedef logic [RANK_W-1:0] rank_t;
    typedef logic [NUM_W-1:0]  excnum_t;
endpackage

// File: rtl/irq_cfg_pend.sv
module irq_cfg_pend
    import irq_nest_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_IRQ-1:0]         irq_in,
    input  logic                     nmi_in,
    input  logic                     fault_in,
    input  logic                     cfg_we,
    input  logic [CFG_AW-1:0]        cfg_addr,
    input  logic [N_IRQ-1:0]         cfg_wdata,
    input  logic                     clr_valid,
    input  logic [NUM_W-1:0]         clr_num,
    output logic [N_IRQ-1:0]         irq_pend,
    output logic                     nmi_pend,
    output logic                     fault_pend,
    output logic [N_IRQ*PRIO_W-1:0]  prio_flat
);
    typedef struct packed {
        logic [N_IRQ-1:0]        en;
        logic [N_IRQ*PRIO_W-1:0] prio;
        logic [N_IRQ-1:0]        pend;
        logic                    nmi_pend;
        logic                    fault_pend;
        logic [N_IRQ-1:0]        irq_prev;
        logic                    nmi_prev;
        logic                    fault_prev;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // configuration writes
        if (cfg_we) begin
            if (cfg_addr == '0) begin
                st_d.en = cfg_wdata;
            end
            for (int w = 0; w < N_PRIO_WORDS; w++) begin
                if (cfg_addr == CFG_AW'(w + 1)) begin
                    for (int k = 0; k < IRQ_PER_WORD; k++) begin
                        st_d.prio[(w*IRQ_PER_WORD + k)*PRIO_W +: PRIO_W] =
                            cfg_wdata[k*PRIO_W +: PRIO_W];
                    end
                end
            end
        end
        // clear on entry acknowledge
        if (clr_valid) begin
            if (clr_num == NUM_W'(NUM_NMI))   st_d.nmi_pend   = 1'b0;
            if (clr_num == NUM_W'(NUM_FAULT)) st_d.fault_pend = 1'b0;
            for (int i = 0; i < N_IRQ; i++) begin
                if (clr_num == NUM_W'(IRQ_BASE + i)) st_d.pend[i] = 1'b0;
            end
        end
        // edge capture wins over a same-cycle clear
        st_d.pend       = st_d.pend | (irq_in & ~st_q.irq_prev & st_q.en);
        st_d.nmi_pend   = st_d.nmi_pend | (nmi_in & ~st_q.nmi_prev);
        st_d.fault_pend = st_d.fault_pend | (fault_in & ~st_q.fault_prev);
        st_d.irq_prev   = irq_in;
        st_d.nmi_prev   = nmi_in;
        st_d.fault_prev = fault_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_pend   = st_q.pend;
    assign nmi_pend   = st_q.nmi_pend;
    assign fault_pend = st_q.fault_pend;
    assign prio_flat  = st_q.prio;

    // R1: a line that was disabled cannot become newly pending
    assert_pend_needs_enable_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_q.pend) == '0 && $past(st_q.en) == '0) |-> st_q.pend == '0);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_nest_pkg::*;
(
    input  logic [N_IRQ-1:0]         irq_pend,
    input  logic                     nmi_pend,
    input  logic                     fault_pend,
    input  logic [N_IRQ*PRIO_W-1:0]  prio_flat,
    output logic                     best_valid,
    output logic [NUM_W-1:0]         best_num,
    output logic [RANK_W-1:0]        best_rank
);
    logic [N_IRQ-1:0][RANK_W-1:0] line_rank;

    for (genvar g = 0; g < N_IRQ; g++) begin : g_rank
        assign line_rank[g] = RANK_W'(RANK_LVL0) + RANK_W'(prio_flat[g*PRIO_W +: PRIO_W]);
    end

    always_comb begin
        best_rank = RANK_W'(RANK_THREAD);
        best_num  = '0;
        if (nmi_pend) begin
            best_rank = RANK_W'(RANK_NMI);
            best_num  = NUM_W'(NUM_NMI);
        end else if (fault_pend) begin
            best_rank = RANK_W'(RANK_FAULT);
            best_num  = NUM_W'(NUM_FAULT);
        end else begin
            // strict compare in ascending order keeps the lowest line on ties
            for (int i = 0; i < N_IRQ; i++) begin
                if (irq_pend[i] && line_rank[i] < best_rank) begin
                    best_rank = line_rank[i];
                    best_num  = NUM_W'(IRQ_BASE + i);
                end
            end
        end
        best_valid = best_rank != RANK_W'(RANK_THREAD);
    end
endmodule

// File: rtl/irq_active_stack.sv
module irq_active_stack
    import irq_nest_pkg::*;
#(
    parameter int DEPTH = STACK_DEPTH
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [RANK_W-1:0] push_rank,
    input  logic              pop,
    output logic [RANK_W-1:0] top_rank,
    output logic [RANK_W-1:0] below_rank
);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][RANK_W-1:0] ent;
        logic [CW-1:0]                cnt;
    } stk_state_t;

    stk_state_t st_d, st_q;

    always_comb begin
        top_rank   = RANK_W'(RANK_THREAD);
        below_rank = RANK_W'(RANK_THREAD);
        for (int k = 0; k < DEPTH; k++) begin
            if (st_q.cnt == CW'(k + 1)) top_rank   = st_q.ent[k];
            if (st_q.cnt == CW'(k + 2)) below_rank = st_q.ent[k];
        end
    end

    always_comb begin
        st_d = st_q;
        if (push) begin
            for (int k = 0; k < DEPTH; k++) begin
                if (st_q.cnt == CW'(k)) st_d.ent[k] = push_rank;
            end
            st_d.cnt = st_q.cnt + 1'b1;
        end else if (pop) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> st_q.cnt < CW'(DEPTH));
    assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> st_q.cnt != '0);
    assert_push_more_urgent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> push_rank < top_rank);
    assert_no_push_and_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop));
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
    import irq_nest_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_IRQ-1:0]     irq_in,
    input  logic                 nmi_in,
    input  logic                 fault_in,
    input  logic                 cfg_we,
    input  logic [CFG_AW-1:0]    cfg_addr,
    input  logic [N_IRQ-1:0]     cfg_wdata,
    input  logic                 entered,
    input  logic                 returned,
    output logic                 take_req,
    output logic [NUM_W-1:0]     take_num,
    output logic [RANK_W-1:0]    take_rank,
    output logic                 take_chain,
    output logic [RANK_W-1:0]    exec_rank
);
    typedef enum logic {ST_RUN, ST_ENTRY} phase_t;

    typedef struct packed {
        phase_t              phase;
        logic [NUM_W-1:0]    num;
        logic [RANK_W-1:0]   rank;
        logic                chain;
    } ctl_state_t;

    ctl_state_t st_d, st_q;

    logic [N_IRQ-1:0]        irq_pend;
    logic                    nmi_pend, fault_pend;
    logic [N_IRQ*PRIO_W-1:0] prio_flat;
    logic                    best_valid;
    logic [NUM_W-1:0]        best_num;
    logic [RANK_W-1:0]       best_rank;
    logic [RANK_W-1:0]       top_rank, below_rank;
    logic                    clr_valid, push, pop;

    irq_cfg_pend u_cfg (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .nmi_in(nmi_in), .fault_in(fault_in),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .clr_valid(clr_valid), .clr_num(st_q.num),
        .irq_pend(irq_pend), .nmi_pend(nmi_pend), .fault_pend(fault_pend),
        .prio_flat(prio_flat)
    );

    irq_arbiter u_arb (
        .irq_pend(irq_pend), .nmi_pend(nmi_pend), .fault_pend(fault_pend),
        .prio_flat(prio_flat), .best_valid(best_valid), .best_num(best_num),
        .best_rank(best_rank)
    );

    irq_active_stack #(.DEPTH(STACK_DEPTH)) u_stk (
        .clk(clk), .rst_n(rst_n), .push(push), .push_rank(st_q.rank), .pop(pop),
        .top_rank(top_rank), .below_rank(below_rank)
    );

    always_comb begin
        st_d      = st_q;
        clr_valid = 1'b0;
        push      = 1'b0;
        pop       = 1'b0;
        unique case (st_q.phase)
            ST_RUN: begin
                if (returned) begin
                    pop = 1'b1;
                    if (best_valid && best_rank < below_rank) begin
                        st_d.phase = ST_ENTRY;
                        st_d.num   = best_num;
                        st_d.rank  = best_rank;
                        st_d.chain = 1'b1;
                    end
                end else if (best_valid && best_rank < top_rank) begin
                    st_d.phase = ST_ENTRY;
                    st_d.num   = best_num;
                    st_d.rank  = best_rank;
                    st_d.chain = 1'b0;
                end
            end
            ST_ENTRY: begin
                if (entered) begin
                    push       = 1'b1;
                    clr_valid  = 1'b1;
                    st_d.phase = ST_RUN;
                    st_d.chain = 1'b0;
                end else if (best_valid && best_rank < st_q.rank) begin
                    st_d.num  = best_num;
                    st_d.rank = best_rank;
                end
            end
            default: st_d.phase = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= ST_RUN;
        end else begin
            st_q <= st_d;
        end
    end

    assign take_req   = st_q.phase == ST_ENTRY;
    assign take_num   = st_q.num;
    assign take_rank  = st_q.rank;
    assign take_chain = st_q.chain && take_req;
    assign exec_rank  = top_rank;

    assert_take_preempts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(take_req) |-> take_rank < exec_rank);
    assert_late_only_urgent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (take_req && $past(take_req) && !$past(entered)) |-> take_rank <= $past(take_rank));
    assert_entry_sets_exec_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (take_req && entered) |=> (exec_rank == $past(take_rank) && !take_req));
    assert_chain_after_return_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(take_req) && take_chain) |-> $past(returned));
    assert_entered_only_offered_R6: assert property (@(posedge clk) disable iff (!rst_n)
        entered |-> take_req);
    assert_no_return_in_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        returned |-> !take_req);
endmodule

// File: tb/irq_nest_ctrl_test.sv
`timescale 1ns/1ps
module irq_nest_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = '0;
    logic        nmi_in = 1'b0, fault_in = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        entered = 1'b0, returned = 1'b0;
    logic        take_req, take_chain;
    logic [5:0]  take_num;
    logic [2:0]  take_rank, exec_rank;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    irq_nest_ctrl uut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .nmi_in(nmi_in), .fault_in(fault_in),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .entered(entered), .returned(returned), .take_req(take_req), .take_num(take_num),
        .take_rank(take_rank), .take_chain(take_chain), .exec_rank(exec_rank)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cfg(int addr, logic [31:0] data);
        cfg_we = 1'b1; cfg_addr = 3'(addr); cfg_wdata = data;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic enter_pulse();
        entered = 1'b1; step(); entered = 1'b0;
    endtask

    task automatic return_pulse();
        returned = 1'b1; step(); returned = 1'b0;
    endtask

    task automatic expect_take(string tag, int num, int rank, int chain);
        chk({tag, " take_req"}, int'(take_req), 1);
        chk({tag, " take_num"}, int'(take_num), num);
        chk({tag, " take_rank"}, int'(take_rank), rank);
        chk({tag, " take_chain"}, int'(take_chain), chain);
    endtask

    function automatic int prio_of(int i);
        return (i * 3) % 4;
    endfunction

    initial begin
        #(20 * 20000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual running expected done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        step();
        // R2 R3: reset state
        chk("R3 reset take_req", int'(take_req), 0);
        chk("R3 reset exec_rank", int'(exec_rank), 7);
        // R2: enables reset to 0 -> edge ignored
        irq_in[9] = 1'b1; step(); step();
        chk("R2 reset enables off", int'(take_req), 0);
        irq_in = '0; step();

        cfg(0, 32'hFFFF_FFFF);
        // R2: default priority 0 -> rank 3
        irq_in[31] = 1'b1; step(); step();
        expect_take("R2 default prio", 47, 3, 0);
        enter_pulse();
        chk("R6 exec after entry", int'(exec_rank), 3);
        return_pulse();
        chk("R8 exec after return", int'(exec_rank), 7);
        irq_in = '0; step();

        // program priorities p(i) = 3i mod 4
        for (int w = 0; w < 4; w++) begin
            logic [31:0] d = '0;
            for (int k = 0; k < 8; k++) d[2*k +: 2] = 2'(prio_of(w*8 + k));
            cfg(w + 1, d);
        end

        // R1 R3 R6: sweep every line
        for (int i = 0; i < 32; i++) begin
            irq_in[i] = 1'b1;
            step();
            chk("R6 no take after one edge", int'(take_req), 0);
            step();
            expect_take("R1 R3 sweep", 16 + i, 3 + prio_of(i), 0);
            step();
            chk("R6 take held", int'(take_req), 1);
            enter_pulse();
            chk("R6 cleared after entry", int'(take_req), 0);
            chk("R6 exec rank sweep", int'(exec_rank), 3 + prio_of(i));
            return_pulse();
            chk("R8 sweep return", int'(exec_rank), 7);
            chk("R8 sweep no chain", int'(take_req), 0);
            irq_in = '0; step();
        end

        // R4: tie on priority 3 (lines 1 and 5), then R8 chain
        irq_in[1] = 1'b1; irq_in[5] = 1'b1; step(); step();
        expect_take("R4 tie lower number", 17, 6, 0);
        enter_pulse();
        return_pulse();
        expect_take("R8 tail chain", 21, 6, 1);
        enter_pulse();
        return_pulse();
        chk("R8 back to thread", int'(exec_rank), 7);
        chk("R8 no take at end", int'(take_req), 0);
        irq_in = '0; step();

        // R4: priority beats number (line 2 p2 vs line 3 p1)
        irq_in[2] = 1'b1; irq_in[3] = 1'b1; step(); step();
        expect_take("R4 prio over number", 19, 4, 0);
        enter_pulse();
        return_pulse();
        expect_take("R8 chain to line 2", 18, 5, 1);
        enter_pulse();
        return_pulse();
        irq_in = '0; step();

        // R5: equal rank does not preempt; NMI does
        irq_in[0] = 1'b1; step(); step();
        expect_take("R5 line 0", 16, 3, 0);
        enter_pulse();
        irq_in[4] = 1'b1; step(); step(); step();
        chk("R5 equal no preempt", int'(take_req), 0);
        chk("R5 exec kept", int'(exec_rank), 3);
        nmi_in = 1'b1; step(); step();
        expect_take("R4 R5 nmi preempts", 2, 1, 0);
        enter_pulse();
        chk("R9 nested exec", int'(exec_rank), 1);
        return_pulse();
        chk("R8 unwind to line 0", int'(exec_rank), 3);
        chk("R8 no chain equal", int'(take_req), 0);
        return_pulse();
        expect_take("R8 chain line 4", 20, 3, 1);
        enter_pulse();
        return_pulse();
        chk("R8 thread again", int'(exec_rank), 7);
        irq_in = '0; nmi_in = 1'b0; step();

        // R4: NMI over fault, fault over line 0
        nmi_in = 1'b1; fault_in = 1'b1; step(); step();
        expect_take("R4 nmi over fault", 2, 1, 0);
        enter_pulse();
        return_pulse();
        expect_take("R4 fault chained", 3, 2, 1);
        enter_pulse();
        return_pulse();
        nmi_in = 1'b0; fault_in = 1'b0; step();
        fault_in = 1'b1; irq_in[0] = 1'b1; step(); step();
        expect_take("R4 fault over level 0", 3, 2, 0);
        enter_pulse();
        return_pulse();
        expect_take("R8 chain to line 0", 16, 3, 1);
        enter_pulse();
        return_pulse();
        fault_in = 1'b0; irq_in = '0; step();

        // R7: late arrival
        irq_in[2] = 1'b1; step(); step();
        expect_take("R7 first offer", 18, 5, 0);
        irq_in[0] = 1'b1; step();
        chk("R7 not yet replaced", int'(take_num), 18);
        step();
        expect_take("R7 replaced", 16, 3, 0);
        enter_pulse();
        chk("R7 exec of late one", int'(exec_rank), 3);
        return_pulse();
        expect_take("R7 replaced stays pending", 18, 5, 1);
        enter_pulse();
        return_pulse();
        irq_in = '0; step();

        // R1: edge while disabled is lost
        cfg(0, ~(32'h1 << 7));
        irq_in[7] = 1'b1; step(); step();
        chk("R1 disabled ignored", int'(take_req), 0);
        cfg(0, 32'hFFFF_FFFF);
        step(); step();
        chk("R1 enable later no take", int'(take_req), 0);
        chk("R1 exec thread", int'(exec_rank), 7);
        irq_in = '0; step();

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule